// File: doc/BRIEF.md
# Video Output Underflow Recovery Controller

This block sits between a flow-controlled pixel stream (valid/ready handshake with a start-of-packet marker) and a clocked video output. A free-running timing generator tells the block when it needs a pixel and when a new frame begins. A small FIFO soaks up bursts on the stream side. As long as the stream delivers pixels at least as fast as the video timing consumes them, pixels pass through the FIFO in order. Each one appears on the output one cycle after it was requested.

If the timing asks for a pixel while the FIFO is empty, the block does not stall the video. It outputs a fixed blank value, latches the event in a sticky status bit, and enters a resynchronisation phase. In that phase it accepts and throws away stream beats until a start-of-packet beat arrives. It queues that beat and the beats behind it, then keeps the output blank until the next frame-start strobe. From that point the packet is played out aligned with the fresh frame. The same resynchronisation path is taken after reset. Software clears the sticky bit by writing a one to its bit position.

Top module: `vid_underflow_ctrl`

## Requirements
- R1: After reset, `s_ready` is 1, `vid_data` equals the blank value `BLANK_PIX`, `status` is all zeros, and the block is resynchronising (the R5 behaviour applies).
- R2: While running, each cycle with `pix_req` high takes the oldest queued beat, which appears on `vid_data` in the next cycle; beats leave in arrival order. A cycle with `pix_req` low gives `BLANK_PIX` in the next cycle.
- R3: Outside resynchronisation, `s_ready` is 0 exactly when the FIFO holds `DEPTH` beats; no accepted beat is lost or repeated.
- R4: While running, `pix_req` with an empty FIFO is an underflow. The next cycle shows `BLANK_PIX`, the output keeps following `pix_req` without stalling, and resynchronisation starts.
- R5: During resynchronisation `s_ready` is 1 and every beat without `s_sop` is discarded. A beat offered in the underflow cycle itself is also discarded, and none of these beats ever reaches `vid_data`.
- R6: Once a start-of-packet beat is taken, it and the beats that follow are queued, and the output stays `BLANK_PIX` until a cycle with `frame_start` high. From that cycle on the block is running, so `frame_start` with `pix_req` outputs the start-of-packet beat next cycle.
- R7: `status[2]` becomes 1 in the cycle after an underflow. All other `status` bits always read 0.
- R8: `status[2]` stays 1 until a cycle with `csr_wr` high and `csr_wdata[2]` = 1, which clears it next cycle. A write with `csr_wdata[2]` = 0 leaves it unchanged.
- R9: An underflow in the same cycle as a clearing write leaves `status[2]` at 1.
- R10: `pix_req` during resynchronisation or while waiting for `frame_start` is not an underflow and does not set `status[2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_data | input | DATA_W | Stream pixel |
| s_valid | input | 1 | Stream beat valid |
| s_sop | input | 1 | Beat is the first of a packet |
| s_ready | output | 1 | Block accepts a beat this cycle |
| pix_req | input | 1 | Timing needs an active pixel this cycle |
| frame_start | input | 1 | Timing strobe: first pixel of a new frame |
| vid_data | output | DATA_W | Registered output pixel |
| csr_wr | input | 1 | Status write strobe |
| csr_wdata | input | CSR_W | Status write data (bit 2 clears) |
| status | output | CSR_W | Status word, bit 2 = sticky underflow |

## Verification
The bench alternates stretches of fast and slow upstream traffic, so the FIFO both fills to backpressure and runs dry during active video. It then follows each recovery through discard, hold and frame alignment. If a design lets a stale mid-packet beat through after underflow, or starts the held packet before the frame strobe, the pixel sequence on the output would not match. Directed cases target a clear that coincides with a new underflow, where a design that lets the clear win would lose the event, and a write with bit 2 at zero, which a careless design would treat as a clear. Requests made during resynchronisation are also checked: a design that flags them as underflows would set the status bit without cause.

// File: rtl/vuc_pkg.sv
package vuc_pkg;
    typedef enum logic [1:0] {
        PH_DROP = 2'd0,
        PH_HOLD = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;
endpackage

// File: rtl/vuc_fifo.sv
module vuc_fifo #(
    parameter int DATA_W = 10,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_regs_t;

    fifo_regs_t r_d, r_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty   = (r_q.cnt == '0);
    assign full    = (r_q.cnt == CW'(DEPTH));
    assign head    = mem[r_q.rp];
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    always_comb begin
        r_d = r_q;
        if (flush) begin
            r_d = '0;
        end else begin
            if (do_push) r_d.wp = bump(r_q.wp);
            if (do_pop)  r_d.rp = bump(r_q.rp);
            case ({do_push, do_pop})
                2'b10:   r_d.cnt = r_q.cnt + CW'(1);
                2'b01:   r_d.cnt = r_q.cnt - CW'(1);
                default: r_d.cnt = r_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[r_q.wp] <= wdata;
    end
endmodule

// File: rtl/vuc_status.sv
module vuc_status #(
    parameter int CSR_W  = 8,
    parameter int UF_BIT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_uf,
    input  logic             csr_wr,
    input  logic [CSR_W-1:0] csr_wdata,
    output logic [CSR_W-1:0] status
);
    typedef struct packed {
        logic uf;
    } stat_regs_t;

    stat_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (set_uf)
            r_d.uf = 1'b1;
        else if (csr_wr && csr_wdata[UF_BIT])
            r_d.uf = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        status         = '0;
        status[UF_BIT] = r_q.uf;
    end
endmodule

// File: rtl/vid_underflow_ctrl.sv
module vid_underflow_ctrl
    import vuc_pkg::*;
#(
    parameter int               DATA_W    = 10,
    parameter int               DEPTH     = 16,
    parameter int               CSR_W     = 8,
    parameter logic [DATA_W-1:0] BLANK_PIX = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_valid,
    input  logic              s_sop,
    output logic              s_ready,
    input  logic              pix_req,
    input  logic              frame_start,
    output logic [DATA_W-1:0] vid_data,
    input  logic              csr_wr,
    input  logic [CSR_W-1:0]  csr_wdata,
    output logic [CSR_W-1:0]  status
);
    localparam int UF_BIT = 2;

    typedef struct packed {
        phase_e            ph;
        logic [DATA_W-1:0] pix;
    } ctl_regs_t;

    ctl_regs_t r_d, r_q;

    logic [DATA_W-1:0] fifo_head;
    logic fifo_empty, fifo_full;
    logic align_now, live, uf, take, push;

    assign align_now = (r_q.ph == PH_HOLD) && frame_start;
    assign live      = (r_q.ph == PH_RUN) || align_now;
    assign uf        = live && pix_req && fifo_empty;
    assign take      = live && pix_req && !fifo_empty;
    assign s_ready   = (r_q.ph == PH_DROP) ? 1'b1 : !fifo_full;
    assign push      = s_valid && s_ready && !uf && ((r_q.ph != PH_DROP) || s_sop);

    vuc_fifo #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .flush(uf),
        .push (push),
        .wdata(s_data),
        .pop  (take),
        .head (fifo_head),
        .empty(fifo_empty),
        .full (fifo_full)
    );

    vuc_status #(
        .CSR_W (CSR_W),
        .UF_BIT(UF_BIT)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_uf   (uf),
        .csr_wr   (csr_wr),
        .csr_wdata(csr_wdata),
        .status   (status)
    );

    always_comb begin
        r_d     = r_q;
        r_d.pix = take ? fifo_head : BLANK_PIX;
        unique case (r_q.ph)
            PH_DROP: if (push) r_d.ph = PH_HOLD;
            PH_HOLD: if (frame_start) r_d.ph = PH_RUN;
            PH_RUN:  r_d.ph = PH_RUN;
            default: r_d.ph = PH_DROP;
        endcase
        if (uf) r_d.ph = PH_DROP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.ph  <= PH_DROP;
            r_q.pix <= BLANK_PIX;
        end else begin
            r_q <= r_d;
        end
    end

    assign vid_data = r_q.pix;
endmodule

// File: rtl/vuc_chk.sv
module vuc_chk #(
    parameter int               DATA_W    = 10,
    parameter int               CSR_W     = 8,
    parameter logic [DATA_W-1:0] BLANK_PIX = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_ready,
    input logic              pix_req,
    input logic [DATA_W-1:0] vid_data,
    input logic              csr_wr,
    input logic [CSR_W-1:0]  csr_wdata,
    input logic [CSR_W-1:0]  status,
    input logic              fifo_full,
    input logic              in_drop,
    input logic              uf
);
    AST_UF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        uf |=> status[2] && vid_data == BLANK_PIX); // R4
    AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] && !(csr_wr && csr_wdata[2]) |=> status[2]); // R8
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        uf && csr_wr && csr_wdata[2] |=> status[2]); // R9
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        !uf && csr_wr && csr_wdata[2] |=> !status[2]); // R8
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !status[2] && !uf |=> !status[2]); // R10
    AST_DROP_READY: assert property (@(posedge clk) disable iff (!rst_n)
        in_drop |-> s_ready); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full && !in_drop |-> !s_ready); // R3
    AST_IDLE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_req |=> vid_data == BLANK_PIX); // R2
    AST_OTHER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~(CSR_W'(1) << 2)) == '0); // R7
endmodule

bind vid_underflow_ctrl vuc_chk #(
    .DATA_W   (DATA_W),
    .CSR_W    (CSR_W),
    .BLANK_PIX(BLANK_PIX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_ready  (s_ready),
    .pix_req  (pix_req),
    .vid_data (vid_data),
    .csr_wr   (csr_wr),
    .csr_wdata(csr_wdata),
    .status   (status),
    .fifo_full(fifo_full),
    .in_drop  (r_q.ph == vuc_pkg::PH_DROP),
    .uf       (uf)
);

// File: tb/vid_underflow_ctrl_tb.sv
module vid_underflow_ctrl_tb;
    localparam int DATA_W = 10;
    localparam int DEPTH  = 16;
    localparam int CSR_W  = 8;
    localparam logic [DATA_W-1:0] BLANK = 10'h040;

    localparam int M_DROP = 0;
    localparam int M_HOLD = 1;
    localparam int M_RUN  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DATA_W-1:0] s_data = '0;
    logic s_valid = 1'b0, s_sop = 1'b0, pix_req = 1'b0, frame_start = 1'b0, csr_wr = 1'b0;
    logic [CSR_W-1:0] csr_wdata = '0;
    logic s_ready;
    logic [DATA_W-1:0] vid_data;
    logic [CSR_W-1:0] status;

    always #2 clk = ~clk;

    vid_underflow_ctrl #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .CSR_W(CSR_W), .BLANK_PIX(BLANK)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid), .s_sop(s_sop),
        .s_ready(s_ready), .pix_req(pix_req), .frame_start(frame_start),
        .vid_data(vid_data), .csr_wr(csr_wr), .csr_wdata(csr_wdata), .status(status)
    );

    int vectors = 0;
    int errors = 0;
    bit finished = 0;

    int m_ph = M_DROP;
    logic [DATA_W-1:0] m_q[$];
    logic m_uf = 1'b0;
    logic [DATA_W-1:0] exp_vid = BLANK;
    string vid_tag = "R1";
    string stat_tag = "R1";
    bit have_exp = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_ready();
        if (m_ph == M_DROP) return 1'b1;
        return (m_q.size() < DEPTH);
    endfunction

    function automatic logic [CSR_W-1:0] exp_status();
        logic [CSR_W-1:0] s = '0;
        s[2] = m_uf;
        return s;
    endfunction

    task automatic step(input logic v, input logic sop, input logic [DATA_W-1:0] d,
                        input logic pr, input logic fs, input logic wr,
                        input logic [CSR_W-1:0] wd, input string stag);
        logic rdy, live, uf, take, push;
        @(negedge clk);
        if (have_exp) begin
            check(vid_tag, 32'(vid_data), 32'(exp_vid));
            check(stat_tag, 32'(status), 32'(exp_status()));
        end
        s_valid = v; s_sop = sop; s_data = d; pix_req = pr;
        frame_start = fs; csr_wr = wr; csr_wdata = wd;
        #1;
        rdy = exp_ready();
        check((m_ph == M_DROP) ? "R5" : "R3", 32'(s_ready), 32'(rdy));
        live = (m_ph == M_RUN) || (m_ph == M_HOLD && fs);
        uf   = live && pr && (m_q.size() == 0);
        take = live && pr && (m_q.size() != 0);
        push = v && rdy && !uf && (m_ph != M_DROP || sop);
        vid_tag = (m_ph == M_DROP) ? "R5" : (m_ph == M_HOLD && !fs) ? "R6" : "R2";
        if (uf) vid_tag = "R4";
        stat_tag = stag;
        if (uf) begin
            exp_vid = BLANK;
            m_q.delete();
            m_ph = M_DROP;
        end else begin
            exp_vid = take ? m_q.pop_front() : BLANK;
            if (push) m_q.push_back(d);
            if (m_ph == M_DROP && push) m_ph = M_HOLD;
            else if (m_ph == M_HOLD && fs) m_ph = M_RUN;
        end
        if (uf) m_uf = 1'b1;
        else if (wr && wd[2]) m_uf = 1'b0;
        have_exp = 1;
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", 32'(s_ready), 32'd1);
        check("R1", 32'(vid_data), 32'(BLANK));
        check("R1", 32'(status), 32'd0);

        // R10: request while resynchronising is not an underflow
        step(0, 0, 10'h000, 1, 0, 0, 8'h00, "R10");
        // R5: non-SOP beat dropped
        step(1, 0, 10'h111, 1, 0, 0, 8'h00, "R10");
        // SOP taken, then hold
        step(1, 1, 10'h222, 1, 0, 0, 8'h00, "R10");
        step(1, 0, 10'h223, 1, 0, 0, 8'h00, "R10");
        // R6: frame start aligns SOP
        step(0, 0, 10'h000, 1, 1, 0, 8'h00, "R6");
        step(0, 0, 10'h000, 1, 0, 0, 8'h00, "R2");
        // R9: underflow coinciding with clear; beat in same cycle dropped (R5)
        step(1, 0, 10'h333, 1, 0, 1, 8'h04, "R9");
        step(0, 0, 10'h000, 1, 0, 0, 8'h00, "R10");
        // R8: write of zero at bit 2 has no effect
        step(0, 0, 10'h000, 0, 0, 1, 8'hFB, "R8");
        step(0, 0, 10'h000, 0, 0, 0, 8'h00, "R8");
        // R8: write one clears
        step(0, 0, 10'h000, 0, 0, 1, 8'h04, "R8");
        step(0, 0, 10'h000, 0, 0, 0, 8'h00, "R7");

        // R3: fill the FIFO to backpressure
        step(1, 1, 10'h300, 0, 0, 0, 8'h00, "R7");
        for (int i = 0; i < DEPTH + 4; i++)
            step(1, 0, 10'(10'h301 + i), 0, 0, 0, 8'h00, "R7");
        step(0, 0, 10'h000, 1, 1, 0, 8'h00, "R6");
        for (int i = 0; i < DEPTH + 2; i++)
            step(0, 0, 10'h000, 1, 0, 0, 8'h00, "R7");

        // Random phases: fast and slow upstream
        for (int ph = 0; ph < 12; ph++) begin
            int vp = (ph % 2 == 0) ? 90 : 25;
            int pp = (ph % 2 == 0) ? 45 : 85;
            for (int c = 0; c < 400; c++) begin
                logic v  = ($urandom % 100) < vp;
                logic sp = ($urandom % 20) == 0;
                logic pr = ($urandom % 100) < pp;
                logic fs = ($urandom % 30) == 0;
                logic wr = ($urandom % 50) == 0;
                logic [CSR_W-1:0] wd = CSR_W'($urandom);
                step(v, sp, DATA_W'($urandom), pr, fs, wr, wd, "R8");
            end
        end
        step(0, 0, 10'h000, 0, 0, 0, 8'h00, "R7");
        @(negedge clk);
        check(vid_tag, 32'(vid_data), 32'(exp_vid));
        check(stat_tag, 32'(status), 32'(exp_status()));
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule